// File: doc/BRIEF.md
# Dual-Master Secondary Interrupt Controller

This block collects edge events from up to `NUM_SRC` peripheral interrupt inputs and presents them to two independent bus masters. Each master, called a line here, has its own copy of the status register, its own mask register and its own active-low interrupt output. The two lines share the per-source edge selection and a control register. Software picks the line it is talking to with a select bit on a simple byte-wide register bus.

Every source input passes through a two-flop synchroniser. A 2-bit field per source then enables detection of its rising edge, its falling edge, or both. A detected edge sets the source's status bit. In exclusive mode it sets the bit on line 0 only; otherwise it sets the bit on both lines. The control register chooses how status is cleared: either a read clears the bits it returned, or software writes ones to clear. The control register also decides whether an edge that arrives on an already-set bit is held and replayed after the clear. A test register lets software force status bits directly.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every status bit is 0, every edge-select bit is 0, the control byte is 0 and both `irq_n` bits are 1.
- R2: `bus_sel` selects line 0 or line 1. With `NUM_SRC`=24 the byte addresses are: status 0..2, mask 3..5, edge select 6..11, control 12, test set 13..15. Status, mask and test-set byte j hold sources 8j..8j+7, least significant bit first. A read presents its data on `bus_rdata` in the cycle after `bus_rd`, with `bus_rvalid` high in that cycle.
- R3: Source i uses edge-select bit 2i (rising) and bit 2i+1 (falling), counted across the edge bytes from address 6 upward. A selected edge on the synchronised input sets the status bit of source i.
- R4: A source whose edge-select field is 00 never sets a status bit, on either edge.
- R5: `irq_n[l]` is 0 exactly when line l has a status bit set whose mask bit is 0. A mask bit of 1 keeps its source off the output.
- R6: Each line has its own status and mask. A write or clear on one line leaves the other line's status and mask unchanged.
- R7: With control bit 0 = 0, writing a 1 to a status bit clears it, and reads of status do not clear anything.
- R8: With control bit 0 = 1, a status read clears the bits it returned on the selected line, and writes to status have no effect.
- R9: With control bit 1 = 0, an edge that arrives while its status bit is set is held, and it sets the bit again right after the clear. With control bit 1 = 1, such an edge is dropped.
- R10: With control bit 2 = 1, edges are recorded only in line 0 status. With control bit 2 = 0, they are recorded in both lines.
- R11: Writing ones to a test-set byte sets the matching status bits of the selected line only. Test-set bytes read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | NUM_SRC | Asynchronous peripheral interrupt inputs |
| bus_sel | input | 1 | Line select for the access: 0 or 1 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| irq_n | output | 2 | Active-low interrupt outputs, bit l for line l |

## Verification
The hardest state to reach is a held second edge. The stimulus has to produce an edge on a source whose status bit is already set, with buffering enabled, and then clear the bit. To get there, the bench selects both edges for one source and raises it. After the synchroniser has settled, it lowers the source again and only then starts clear-on-read reads. It then expects the first two reads to return the bit and the third to return zero. The same sequence is repeated with buffering disabled, where only one read returns the bit. This is also done on the second line, so the held state is shown to be per line.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Control byte layout: bit0 clear-on-read, bit1 drop second edge, bit2 exclusive
  typedef struct packed {
    logic excl;
    logic pdis;
    logic cor;
  } sic_ctrl_t;
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sic_edge.sv
module sic_edge #(
  parameter int N = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] sel_i,
  output logic [N-1:0]   ev_o
);
  logic [N-1:0] lvl, prev_q;

  sic_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    assign ev_o[i] = (sel_i[2*i]   &  lvl[i] & ~prev_q[i])
                   | (sel_i[2*i+1] & ~lvl[i] &  prev_q[i]);
  end
endmodule

// File: rtl/sic_line.sv
module sic_line #(
  parameter int N  = 24,
  parameter int NB = (N + 7) / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ev_i,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  w1c_i,
  input  logic [N-1:0]  rdclr_i,
  input  logic          cor_i,
  input  logic          pdis_i,
  input  logic [NB-1:0] mask_we_i,
  input  logic [7:0]    mask_wdata_i,
  output logic [N-1:0]  status_o,
  output logic [N-1:0]  mask_o,
  output logic          irq_n_o
);
  logic [N-1:0] st_q, st_d, pend_q, pend_d, mask_q, mask_d, clr;

  always_comb begin
    clr  = (cor_i ? rdclr_i : w1c_i) & st_q;
    st_d = (st_q & ~clr) | ev_i | set_i | (pend_q & clr);
    if (pdis_i) pend_d = '0;
    else        pend_d = ((pend_q | (st_q & ev_i)) & ~clr) | (pend_q & ev_i & clr);
    mask_d = mask_q;
    for (int i = 0; i < N; i++) begin
      if (mask_we_i[i/8]) mask_d[i] = mask_wdata_i[i%8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign status_o = st_q;
  assign mask_o   = mask_q;
  assign irq_n_o  = ~|(st_q & ~mask_q);
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               bus_rvalid,
  output logic [1:0]         irq_n
);
  localparam int NB    = (NUM_SRC + 7) / 8;
  localparam int EB    = (2 * NUM_SRC + 7) / 8;
  localparam int A_ST  = 0;
  localparam int A_MK  = NB;
  localparam int A_ED  = 2 * NB;
  localparam int A_CT  = 2 * NB + EB;
  localparam int A_SET = A_CT + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // shared control and edge selection
  sic_ctrl_t         ctrl_q, ctrl_d;
  logic [EB*8-1:0]   edge_q, edge_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_wr && bus_addr == ADDR_W'(A_CT)) ctrl_d = sic_ctrl_t'(bus_wdata[2:0]);
    edge_d = edge_q;
    for (int b = 0; b < EB; b++) begin
      if (bus_wr && bus_addr == ADDR_W'(A_ED + b)) edge_d[8*b +: 8] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctrl_q <= '0;
      edge_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      edge_q <= edge_d;
    end
  end

  // edge events
  logic [NUM_SRC-1:0] ev;
  sic_edge #(.N(NUM_SRC)) u_edge (
    .clk   (clk),
    .rst_n (rst_q_n),
    .src_i (src_i),
    .sel_i (edge_q[2*NUM_SRC-1:0]),
    .ev_o  (ev)
  );

  // per-line access decode
  logic [1:0][NUM_SRC-1:0] w1c, rdclr, tset;
  logic [1:0][NB-1:0]      mk_we;

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        w1c[l][i]   = bus_wr && (bus_sel == l[0]) && bus_addr == ADDR_W'(A_ST + i/8)
                      && bus_wdata[i%8];
        rdclr[l][i] = bus_rd && (bus_sel == l[0]) && bus_addr == ADDR_W'(A_ST + i/8);
        tset[l][i]  = bus_wr && (bus_sel == l[0]) && bus_addr == ADDR_W'(A_SET + i/8)
                      && bus_wdata[i%8];
      end
      for (int b = 0; b < NB; b++) begin
        mk_we[l][b] = bus_wr && (bus_sel == l[0]) && bus_addr == ADDR_W'(A_MK + b);
      end
    end
  end

  // the two lines
  logic [1:0][NUM_SRC-1:0] status_q, mask_q;

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [NUM_SRC-1:0] ev_l;
    if (l == 0) begin : g_first
      assign ev_l = ev;
    end else begin : g_other
      assign ev_l = ctrl_q.excl ? '0 : ev;
    end
    sic_line #(.N(NUM_SRC), .NB(NB)) u_line (
      .clk          (clk),
      .rst_n        (rst_q_n),
      .ev_i         (ev_l),
      .set_i        (tset[l]),
      .w1c_i        (w1c[l]),
      .rdclr_i      (rdclr[l]),
      .cor_i        (ctrl_q.cor),
      .pdis_i       (ctrl_q.pdis),
      .mask_we_i    (mk_we[l]),
      .mask_wdata_i (bus_wdata),
      .status_o     (status_q[l]),
      .mask_o       (mask_q[l]),
      .irq_n_o      (irq_n[l])
    );
  end

  // read path
  logic [NB*8-1:0] st_pad, mk_pad;
  logic [7:0]      rdata_d, rdata_q;
  logic            rvalid_q;

  assign st_pad = (NB*8)'(bus_sel ? status_q[1] : status_q[0]);
  assign mk_pad = (NB*8)'(bus_sel ? mask_q[1]   : mask_q[0]);

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADDR_W'(A_ST + b)) rdata_d = st_pad[8*b +: 8];
      if (bus_addr == ADDR_W'(A_MK + b)) rdata_d = mk_pad[8*b +: 8];
    end
    for (int b = 0; b < EB; b++) begin
      if (bus_addr == ADDR_W'(A_ED + b)) rdata_d = edge_q[8*b +: 8];
    end
    if (bus_addr == ADDR_W'(A_CT)) rdata_d = {5'b0, ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NUM_SRC = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 bus_sel,
  input logic                 cor,
  input logic                 excl,
  input logic [2*NUM_SRC-1:0] edge_sel,
  input logic [NUM_SRC-1:0]   st0,
  input logic [NUM_SRC-1:0]   st1,
  input logic [NUM_SRC-1:0]   mk0,
  input logic [NUM_SRC-1:0]   mk1,
  input logic [1:0]           irq_n,
  input logic                 rvalid
);
  AST_MASKED_LINE0_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (&mk0) |-> irq_n[0]); // R5
  AST_MASKED_LINE1_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (&mk1) |-> irq_n[1]); // R5
  AST_W1C_HOLD_LINE0: assert property (@(posedge clk) disable iff (!rst_n) (!cor && !bus_wr) |=> ((~st0 & $past(st0)) == '0)); // R7
  AST_W1C_HOLD_LINE1: assert property (@(posedge clk) disable iff (!rst_n) (!cor && !bus_wr) |=> ((~st1 & $past(st1)) == '0)); // R7
  AST_EXCL_LINE1_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (excl && !(bus_sel && (bus_wr || bus_rd))) |=> ((st1 & ~$past(st1)) == '0)); // R10
  AST_EDGE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (edge_sel == '0 && !bus_wr && !bus_rd) |=> ((st0 & ~$past(st0)) == '0)); // R4
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> rvalid); // R2
endmodule

bind sec_irq_ctrl sic_checker #(.NUM_SRC(NUM_SRC)) u_sic_checker (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_sel  (bus_sel),
  .cor      (ctrl_q.cor),
  .excl     (ctrl_q.excl),
  .edge_sel (edge_q[2*NUM_SRC-1:0]),
  .st0      (status_q[0]),
  .st1      (status_q[1]),
  .mk0      (mask_q[0]),
  .mk1      (mask_q[1]),
  .irq_n    (irq_n),
  .rvalid   (bus_rvalid)
);

// File: tb/sec_irq_ctrl_bench.sv
module sec_irq_ctrl_bench;
  localparam int N = 24;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          bus_sel;
  logic [AW-1:0] bus_addr;
  logic          bus_wr, bus_rd;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;
  logic          bus_rvalid;
  logic [1:0]    irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u_sec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_n(irq_n)
  );

  // monitor: pops the expected read data as results appear
  always @(negedge clk) begin
    if (bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read data %02h, expected no read", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic sel, input int a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input int a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_sel = sel; bus_addr = AW'(a); bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [1:0] e, input string t);
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n got %b expected %b", t, irq_n, e);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; bus_sel = 1'b0; bus_addr = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(2'b11, "R1");
    rd(0, 0, 8'h00, "R1");
    rd(0, 3, 8'hFF, "R1");
    rd(0, 5, 8'hFF, "R1");
    rd(1, 4, 8'hFF, "R1");
    rd(0, 6, 8'h00, "R1");
    rd(0, 12, 8'h00, "R1");

    // R4 edge field 00: toggling src0 sets nothing
    src[0] = 1'b1; settle(); src[0] = 1'b0; settle();
    rd(0, 0, 8'h00, "R4");
    rd(1, 0, 8'h00, "R4");

    // R3 src0 rising (bit0), src1 falling (bit3)
    wr(0, 6, 8'h09);
    rd(1, 6, 8'h09, "R2");
    src[1:0] = 2'b11; settle();
    rd(0, 0, 8'h01, "R3");
    src[1:0] = 2'b00; settle();
    rd(0, 0, 8'h03, "R3");
    rd(1, 0, 8'h03, "R10");
    chk_irq(2'b11, "R5");

    // R5 unmask src1 on line 0
    wr(0, 3, 8'hFD);
    chk_irq(2'b10, "R5");
    rd(0, 3, 8'hFD, "R6");
    rd(1, 3, 8'hFF, "R6");

    // R7 write-one-to-clear, reads keep status
    rd(1, 0, 8'h03, "R7");
    rd(1, 0, 8'h03, "R7");
    wr(0, 0, 8'h02);
    rd(0, 0, 8'h01, "R7");
    chk_irq(2'b11, "R5");
    rd(1, 0, 8'h03, "R6");
    wr(0, 0, 8'hFF);
    wr(1, 0, 8'hFF);
    rd(0, 0, 8'h00, "R7");
    rd(1, 0, 8'h00, "R7");

    // R10 exclusive mode: only line 0 records
    wr(0, 12, 8'h04);
    wr(1, 3, 8'h00);
    src[0] = 1'b1; settle();
    rd(0, 0, 8'h01, "R10");
    rd(1, 0, 8'h00, "R10");
    chk_irq(2'b11, "R10");
    wr(0, 0, 8'h01);
    wr(1, 3, 8'hFF);
    src[0] = 1'b0; settle();

    // R8 clear-on-read, writes ignored
    wr(0, 12, 8'h01);
    rd(0, 12, 8'h01, "R2");
    src[0] = 1'b1; settle();
    wr(0, 0, 8'hFF);
    rd(0, 0, 8'h01, "R8");
    rd(0, 0, 8'h00, "R8");
    rd(1, 0, 8'h01, "R8");
    rd(1, 0, 8'h00, "R8");
    src[0] = 1'b0; settle();

    // R9 held second edge replays after clear
    wr(0, 6, 8'h30);
    src[2] = 1'b1; settle();
    src[2] = 1'b0; settle();
    rd(0, 0, 8'h04, "R9");
    rd(0, 0, 8'h04, "R9");
    rd(0, 0, 8'h00, "R9");
    rd(1, 0, 8'h04, "R9");
    rd(1, 0, 8'h04, "R9");
    rd(1, 0, 8'h00, "R9");

    // R9 second edge dropped when bit1 set
    wr(0, 12, 8'h03);
    src[2] = 1'b1; settle();
    src[2] = 1'b0; settle();
    rd(0, 0, 8'h04, "R9");
    rd(0, 0, 8'h00, "R9");
    rd(1, 0, 8'h04, "R9");
    rd(1, 0, 8'h00, "R9");

    // R11 test set register on line 1
    wr(0, 12, 8'h00);
    wr(1, 15, 8'h80);
    rd(1, 2, 8'h80, "R11");
    rd(0, 2, 8'h00, "R11");
    rd(1, 15, 8'h00, "R11");
    wr(1, 5, 8'h7F);
    chk_irq(2'b01, "R11");
    wr(1, 2, 8'h80);
    chk_irq(2'b11, "R7");

    // R3 highest source: src23 rising is edge bit 46 (byte 11 bit 6)
    wr(0, 11, 8'h40);
    src[23] = 1'b1; settle();
    rd(0, 2, 8'h80, "R3");
    chk_irq(2'b01, "R5");
    rd(0, 11, 8'h40, "R2");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d reads never returned data, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule